// File: doc/BRIEF.md
# Fully Associative Tag Store with Selectable Eviction

This block holds the tags of a small fully associative cache and picks which line to overwrite when a lookup misses. Any memory block may sit in any line. A lookup address has only two parts: a tag in the upper bits and a word offset in the low bits. The offset is never compared. Every valid line's tag is compared with the lookup tag at the same time. The data array and the refill path are outside the block. The block reports which line holds the block, or which line the block has just been given.

After reset the store is empty. While a free line remains, a miss takes the lowest-numbered free line. Once every line is in use, a two-bit select chooses how the victim is found:
- Least recently used: per-line timestamps are loaded from a reference counter that advances on every lookup.
- First-in-first-out or last-in-first-out: per-line load-order stamps are written only when a line is filled.
- Pseudo-random: the index comes from a free-running shift register.

Each miss updates the tag store at once, so the next lookup of the same block hits.

Top module: `fa_repl_unit`

## Requirements
- R1: A lookup presented with `req_valid` high at a rising edge gives `rsp_valid` high after that edge for exactly one cycle. With `req_valid` low, `rsp_valid` stays low.
- R2: The tag is `req_addr[23:2]` and the offset is `req_addr[1:0]`. The offset is ignored, so addresses that differ only in the offset hit the same line. A hit sets `rsp_hit`=1 and puts the matching line's index on `rsp_line`.
- R3: Reset (active high, synchronous) marks every line invalid and clears `rsp_valid`, `rsp_hit` and `rsp_evict`. Afterwards a tag cached before the reset misses.
- R4: While any line is invalid, a miss fills the lowest-numbered invalid line and reports `rsp_evict`=0, whatever the policy.
- R5: With `policy`=0 (least recently used), a reference counter advances on every lookup. A line's timestamp takes the counter value on a fill and on a hit. On a miss with all lines valid, the line with the oldest timestamp is replaced.
- R6: With `policy`=1 (first-in-first-out), a miss with all lines valid replaces the line filled earliest. Hits on a line do not change this order.
- R7: With `policy`=2 (last-in-first-out), a miss with all lines valid replaces the line filled most recently. Hits on a line do not change this order.
- R8: With `policy`=3 (pseudo-random), a miss with all lines valid replaces a line whose index is below the line count.
- R9: On a miss, `rsp_line` gives the line that received the new tag. `rsp_evict`=1 exactly when that line held a valid tag before. A hit always reports `rsp_evict`=0.
- R10: After a miss fills a line, the next lookup of the same tag hits on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | 24 | Lookup address: tag in [23:2], word offset in [1:0] |
| policy | input | 2 | Eviction select: 0 LRU, 1 FIFO, 2 LIFO, 3 random |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | The lookup matched a valid line |
| rsp_line | output | 2 | Line that matched, or the line that was filled |
| rsp_evict | output | 1 | The fill displaced a valid line |

## Verification
Every result (`rsp_valid`, `rsp_hit`, `rsp_line`, `rsp_evict`) is registered. Each one is due in the cycle after the rising edge that accepted the lookup, and the tag store and stamps are updated at that same edge. The bench drives a lookup on a falling edge and drops `req_valid` on the next falling edge. It reads the outputs at that second falling edge, which falls half a cycle after the edge that registered them. A lookup that follows therefore sees the store as the previous lookup left it.

// File: rtl/fa_repl_pkg.sv
package fa_repl_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_FIFO = 2'd1,
    POL_LIFO = 2'd2,
    POL_RAND = 2'd3
  } pol_e;
endpackage

// File: rtl/fa_tag_match.sv
// Parallel tag compare plus lowest-free-line search.
module fa_tag_match #(
  parameter int LINES = 3,
  parameter int TAG_W = 22,
  parameter int IDX_W = 2
) (
  input  logic [LINES-1:0] line_ok,
  input  logic [TAG_W-1:0] line_tag [LINES],
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic             has_free,
  output logic [IDX_W-1:0] free_idx
);
  logic [LINES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_cmp
      assign match[g] = line_ok[g] && (line_tag[g] == look_tag);
    end
  endgenerate

  always_comb begin
    hit      = |match;
    has_free = ~&line_ok;
    hit_idx  = '0;
    free_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match[i])    hit_idx  = IDX_W'(i);
      if (!line_ok[i]) free_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_victim_pick.sv
// Chooses the line to replace once every line is valid.
module fa_victim_pick
  import fa_repl_pkg::*;
#(
  parameter int LINES   = 3,
  parameter int STAMP_W = 16,
  parameter int IDX_W   = 2
) (
  input  pol_e               policy,
  input  logic [STAMP_W-1:0] use_stamp  [LINES],
  input  logic [STAMP_W-1:0] load_stamp [LINES],
  input  logic [IDX_W-1:0]   rnd_idx,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] oldest_use, oldest_load, newest_load;

  always_comb begin
    oldest_use  = '0;
    oldest_load = '0;
    newest_load = '0;
    for (int i = 1; i < LINES; i++) begin
      if (use_stamp[i]  < use_stamp[oldest_use])    oldest_use  = IDX_W'(i);
      if (load_stamp[i] < load_stamp[oldest_load])  oldest_load = IDX_W'(i);
      if (load_stamp[i] > load_stamp[newest_load])  newest_load = IDX_W'(i);
    end
    unique case (policy)
      POL_LRU:  victim = oldest_use;
      POL_FIFO: victim = oldest_load;
      POL_LIFO: victim = newest_load;
      default:  victim = rnd_idx;
    endcase
  end
endmodule

// File: rtl/fa_lfsr.sv
// Free-running 8-bit LFSR reduced to a line index.
module fa_lfsr #(
  parameter int LINES  = 3,
  parameter int IDX_W  = 2,
  parameter int LFSR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] rnd_idx
);
  logic [LFSR_W-1:0] s_q;
  logic              fb;

  assign fb = s_q[7] ^ s_q[5] ^ s_q[4] ^ s_q[3];

  always_ff @(posedge clk) begin
    if (rst) s_q <= LFSR_W'(1);
    else     s_q <= {s_q[LFSR_W-2:0], fb};
  end

  assign rnd_idx = IDX_W'(s_q % LFSR_W'(LINES));
endmodule

// File: rtl/fa_repl_unit.sv
module fa_repl_unit
  import fa_repl_pkg::*;
#(
  parameter int TAG_W   = 22,
  parameter int OFF_W   = 2,
  parameter int LINES   = 3,
  parameter int STAMP_W = 16,
  localparam int ADDR_W = TAG_W + OFF_W,
  localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        policy,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_line,
  output logic              rsp_evict
);
  logic [LINES-1:0]   ok_q;
  logic [TAG_W-1:0]   tag_q  [LINES];
  logic [STAMP_W-1:0] use_q  [LINES];
  logic [STAMP_W-1:0] load_q [LINES];
  logic [STAMP_W-1:0] ref_clk_q, load_clk_q;

  logic [TAG_W-1:0] look_tag;
  logic             hit, has_free;
  logic [IDX_W-1:0] hit_idx, free_idx, victim, rnd_idx, target;

  assign look_tag = req_addr[ADDR_W-1:OFF_W];

  fa_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .line_ok  (ok_q),
    .line_tag (tag_q),
    .look_tag (look_tag),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .has_free (has_free),
    .free_idx (free_idx)
  );

  fa_lfsr #(.LINES(LINES), .IDX_W(IDX_W)) u_rnd (
    .clk     (clk),
    .rst     (rst),
    .rnd_idx (rnd_idx)
  );

  fa_victim_pick #(.LINES(LINES), .STAMP_W(STAMP_W), .IDX_W(IDX_W)) u_pick (
    .policy     (pol_e'(policy)),
    .use_stamp  (use_q),
    .load_stamp (load_q),
    .rnd_idx    (rnd_idx),
    .victim     (victim)
  );

  assign target = hit ? hit_idx : (has_free ? free_idx : victim);

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q       <= '0;
      ref_clk_q  <= '0;
      load_clk_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_line   <= '0;
      rsp_evict  <= 1'b0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        use_q[i]  <= '0;
        load_q[i] <= '0;
      end
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit;
      rsp_evict <= req_valid && !hit && !has_free;
      if (req_valid) begin
        rsp_line       <= target;
        ref_clk_q      <= ref_clk_q + 1'b1;
        use_q[target]  <= ref_clk_q;
        if (!hit) begin
          ok_q[target]   <= 1'b1;
          tag_q[target]  <= look_tag;
          load_q[target] <= load_clk_q;
          load_clk_q     <= load_clk_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fa_repl_chk.sv
module fa_repl_chk #(
  parameter int TAG_W = 22,
  parameter int OFF_W = 2,
  parameter int LINES = 3,
  parameter int IDX_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic [TAG_W+OFF_W-1:0] req_addr,
  input logic                   rsp_valid,
  input logic                   rsp_hit,
  input logic [IDX_W-1:0]       rsp_line,
  input logic                   rsp_evict
);
  logic [IDX_W:0] fills_q;

  always_ff @(posedge clk) begin
    if (rst) fills_q <= '0;
    else if (rsp_valid && !rsp_hit && fills_q < (IDX_W+1)'(LINES))
      fills_q <= fills_q + 1'b1;
  end

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_line_range_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ({1'b0, rsp_line} < (IDX_W+1)'(LINES)));
  p_hit_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> !rsp_evict);
  p_fill_free_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit && fills_q < (IDX_W+1)'(LINES)) |-> !rsp_evict);
  p_repeat_hit_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid) && !$past(rst) &&
     req_addr[TAG_W+OFF_W-1:OFF_W] == $past(req_addr[TAG_W+OFF_W-1:OFF_W]))
    |=> (rsp_hit && rsp_line == $past(rsp_line)));
endmodule

bind fa_repl_unit fa_repl_chk #(
  .TAG_W(TAG_W), .OFF_W(OFF_W), .LINES(LINES), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/tb_fa_repl_unit.sv
`timescale 1ns/1ps
module tb_fa_repl_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  policy = '0;
  logic        rsp_valid, rsp_hit, rsp_evict;
  logic [1:0]  rsp_line;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  fa_repl_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .policy(policy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_line(rsp_line), .rsp_evict(rsp_evict)
  );

  typedef struct packed {
    logic        rst;
    logic [1:0]  pol;
    logic [21:0] tag;
    logic [1:0]  off;
    logic        hit;
    logic [1:0]  line;
    logic        evict;
  } vec_t;

  localparam logic [21:0] TA = 22'h0A001, TB = 22'h0B002, TC = 22'h0C003,
                          TD = 22'h2D004, TE = 22'h3E005;
  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    // R5 least recently used
    '{1'b1, 2'd0, TA, 2'd0, 1'b0, 2'd0, 1'b0},
    '{1'b0, 2'd0, TB, 2'd1, 1'b0, 2'd1, 1'b0},
    '{1'b0, 2'd0, TC, 2'd2, 1'b0, 2'd2, 1'b0},
    '{1'b0, 2'd0, TA, 2'd3, 1'b1, 2'd0, 1'b0},
    '{1'b0, 2'd0, TD, 2'd0, 1'b0, 2'd1, 1'b1},
    '{1'b0, 2'd0, TC, 2'd1, 1'b1, 2'd2, 1'b0},
    '{1'b0, 2'd0, TE, 2'd0, 1'b0, 2'd0, 1'b1},
    '{1'b0, 2'd0, TB, 2'd0, 1'b0, 2'd1, 1'b1},
    // R6 first-in-first-out (first entry also R3: TA misses after reset)
    '{1'b1, 2'd1, TA, 2'd0, 1'b0, 2'd0, 1'b0},
    '{1'b0, 2'd1, TB, 2'd0, 1'b0, 2'd1, 1'b0},
    '{1'b0, 2'd1, TC, 2'd0, 1'b0, 2'd2, 1'b0},
    '{1'b0, 2'd1, TA, 2'd1, 1'b1, 2'd0, 1'b0},
    '{1'b0, 2'd1, TA, 2'd2, 1'b1, 2'd0, 1'b0},
    '{1'b0, 2'd1, TD, 2'd0, 1'b0, 2'd0, 1'b1},
    '{1'b0, 2'd1, TE, 2'd0, 1'b0, 2'd1, 1'b1},
    '{1'b0, 2'd1, TA, 2'd0, 1'b0, 2'd2, 1'b1},
    // R7 last-in-first-out
    '{1'b1, 2'd2, TA, 2'd0, 1'b0, 2'd0, 1'b0},
    '{1'b0, 2'd2, TB, 2'd0, 1'b0, 2'd1, 1'b0},
    '{1'b0, 2'd2, TC, 2'd0, 1'b0, 2'd2, 1'b0},
    '{1'b0, 2'd2, TC, 2'd1, 1'b1, 2'd2, 1'b0},
    '{1'b0, 2'd2, TA, 2'd0, 1'b1, 2'd0, 1'b0},
    '{1'b0, 2'd2, TD, 2'd0, 1'b0, 2'd2, 1'b1},
    '{1'b0, 2'd2, TE, 2'd0, 1'b0, 2'd2, 1'b1},
    '{1'b0, 2'd2, TB, 2'd0, 1'b1, 2'd1, 1'b0},
    '{1'b0, 2'd2, TE, 2'd3, 1'b1, 2'd2, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic access(input logic [1:0] pol, input logic [21:0] tag,
                        input logic [1:0] off);
    @(negedge clk);
    policy    = pol;
    req_addr  = {tag, off};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] rline;
    repeat (2) @(negedge clk);
    // R3 reset state
    chk("R3", "rsp_valid in reset", 32'(rsp_valid), 0);
    chk("R3", "rsp_evict in reset", 32'(rsp_evict), 0);
    rst = 1'b0;
    @(negedge clk);
    // R1 no response without a request
    chk("R1", "rsp_valid idle", 32'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rst) do_reset();
      access(TBL[i].pol, TBL[i].tag, TBL[i].off);
      chk("R1", $sformatf("v%0d rsp_valid", i), 32'(rsp_valid), 1);
      chk("R2/R10", $sformatf("v%0d rsp_hit", i), 32'(rsp_hit), 32'(TBL[i].hit));
      chk("R4/R5/R6/R7", $sformatf("v%0d rsp_line", i), 32'(rsp_line), 32'(TBL[i].line));
      chk("R9", $sformatf("v%0d rsp_evict", i), 32'(rsp_evict), 32'(TBL[i].evict));
    end

    // R1 response lasts one cycle
    @(negedge clk);
    chk("R1", "rsp_valid drops", 32'(rsp_valid), 0);

    // R8 random eviction once full
    do_reset();
    access(2'd3, TA, 2'd0);
    access(2'd3, TB, 2'd0);
    access(2'd3, TC, 2'd0);
    chk("R4", "third fill line", 32'(rsp_line), 2);
    access(2'd3, TD, 2'd0);
    chk("R8", "random miss", 32'(rsp_hit), 0);
    chk("R8", "random evict", 32'(rsp_evict), 1);
    chk("R8", "random line in range", 32'(rsp_line < 2'd3), 1);
    rline = rsp_line;
    access(2'd3, TD, 2'd1);
    chk("R10", "hit after random fill", 32'(rsp_hit), 1);
    chk("R10", "same line after fill", 32'(rsp_line), 32'(rline));

    // R3 reset mid-run clears outputs and empties store
    do_reset();
    chk("R3", "rsp_hit after reset", 32'(rsp_hit), 0);
    access(2'd0, TD, 2'd0);
    chk("R3", "cached tag misses after reset", 32'(rsp_hit), 0);
    chk("R4", "fill after reset line", 32'(rsp_line), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule